// File: doc/BRIEF.md
# Transmit I/Q Sample Source

This block feeds a radio transmitter with a continuous stream of paired in-phase and quadrature samples. Two producers sit behind one runtime selector. The first is a built-in test tone: a four-step quadrature sequence that gives a single carrier at one quarter of the sample rate. With it, the transmit chain can be checked without any software setup. The second is a memory-to-stream engine. It fetches a buffer of packed sample words over a Wishbone master port and replays them on the stream.

Software programs the engine through a small word-addressed register port. It writes the buffer start address and the word count, then issues a start command. After that it does not take part until the completion interrupt fires. The selector input may change at any time. The output switches only between samples, so every pair on the stream comes whole from one producer.

Top module: `tx_iq_source`

## Requirements
- R1: After reset the tone source is selected, the tone output shows its first step, `irq_o` is low, no bus cycle is active, and all register reads return 0.
- R2: The tone steps through (I,Q) = (+A,0), (0,+A), (−A,0), (0,−A) and then repeats. A = 2046 (12-bit two's complement: +A = 0x7FE, −A = 0x802). The step advances only when the tone sample is accepted, and the tone is always valid while selected.
- R3: A change on `src_sel_i` (0 = tone, 1 = memory) takes effect only when no sample is waiting unaccepted on the output. The held sample is always delivered first, and the tone resumes at the step where it stopped.
- R4: Each 32-bit memory word carries one pair. I is in bits [11:0] of the lower half-word and Q is in bits [27:16] of the upper half-word. Both half-words are sign-extended, and the samples appear in buffer order.
- R5: Register offsets on `cfg_addr_i` are: 0 buffer byte address (read/write), 1 word count (read/write), 2 control (writing bit 0 = 1 starts a transfer; bit 0 reads as busy), 3 interrupt (bit 0 flag, bit 1 enable).
- R6: A start command issued while a transfer is busy has no effect. The transfer reads exactly the programmed number of words and then stops delivering samples.
- R7: Memory reads are single classic Wishbone reads at base, base+4, base+8, and so on. Cycle and strobe stay asserted with a stable address until acknowledge, and only one read is outstanding at a time.
- R8: The engine buffers at most DEPTH words (default 4). With the stream stalled, exactly DEPTH reads complete and no more are issued.
- R9: The interrupt flag sets when the last buffer sample is accepted on the stream. It is cleared only by writing 1 to bit 0 of the interrupt register. `irq_o` is the flag AND the enable.
- R10: A start with a word count of zero sets the flag at once and issues no bus cycle.
- R11: A sample that is valid but not accepted stays valid and unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 1 | Source select: 0 tone, 1 memory stream |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register word offset |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data (combinational) |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable, always 0 |
| wb_adr_o | output | 32 | Wishbone byte address |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| tx_valid_o | output | 1 | Sample valid |
| tx_ready_i | input | 1 | Sample accepted by the transmitter |
| tx_i_o | output | 12 | In-phase sample |
| tx_q_o | output | 12 | Quadrature sample |
| irq_o | output | 1 | Transfer-complete interrupt |

## Verification
The bench switches sources while a tone sample is held stalled. A selector that switched mid-stall would lose or duplicate a tone step, or would show a memory sample in place of the held one. It also stalls the stream during a transfer and counts completed reads. An engine that did not bound its buffer would read past DEPTH words, and one that stopped early would deadlock. A second start command is sent mid-transfer, where a design that restarted would replay or over-read the buffer. The bench also runs a zero-length start, which a faulty design would either never complete or would turn into a bus cycle. Interrupt write-one-to-clear and the enable gating are checked on both edges of the flag.

// File: rtl/tx_iq_pkg.sv
package tx_iq_pkg;
  localparam int IQ_W   = 12;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 32;
  localparam int HALF_W = WORD_W / 2;

  typedef struct packed {
    logic [IQ_W-1:0] q;
    logic [IQ_W-1:0] i;
  } iq_t;

  typedef enum logic {
    SRC_TONE = 1'b0,
    SRC_DMA  = 1'b1
  } src_e;

  localparam logic [1:0] REG_BASE = 2'd0;
  localparam logic [1:0] REG_LEN  = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;
  localparam logic [1:0] REG_IRQ  = 2'd3;
endpackage

// File: rtl/tx_tone_gen.sv
module tx_tone_gen
  import tx_iq_pkg::*;
#(
  parameter int AMP = (1 << (IQ_W - 1)) - 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  output logic valid_o,
  output iq_t  data_o
);
  localparam logic [IQ_W-1:0] POS = IQ_W'(AMP);
  localparam logic [IQ_W-1:0] NEG = IQ_W'(-AMP);

  logic [1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      phase_q <= '0;
    else if (ready_i) phase_q <= phase_q + 2'd1;
  end

  always_comb begin
    data_o = '0;
    unique case (phase_q)
      2'd0: data_o.i = POS;
      2'd1: data_o.q = POS;
      2'd2: data_o.i = NEG;
      default: data_o.q = NEG;
    endcase
  end

  assign valid_o = 1'b1;
endmodule

// File: rtl/tx_dma_fifo.sv
module tx_dma_fifo #(
  parameter int WIDTH = 24,
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign count_o = cnt_q;
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign data_o  = mem_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      unique case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/tx_dma_reader.sv
module tx_dma_reader
  import tx_iq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LEN_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  input  logic [WORD_W-1:0] wb_dat_i,
  input  logic              wb_ack_i,
  output logic              valid_o,
  input  logic              ready_i,
  output iq_t               data_o,
  output logic [CNT_W-1:0]  fill_o
);
  localparam logic [ADDR_W-1:0] ADR_STEP = ADDR_W'(WORD_W / 8);

  logic              busy_q, cyc_q;
  logic [ADDR_W-1:0] adr_q;
  logic [LEN_W-1:0]  req_left_q, out_left_q;
  logic              take, pop, empty, full, issue, accept;
  iq_t               word_iq;

  assign accept = start_i & ~busy_q;
  assign take   = cyc_q & wb_ack_i;
  assign pop    = valid_o & ready_i;
  assign issue  = busy_q & ~cyc_q & (req_left_q != '0) & (fill_o < CNT_W'(DEPTH));
  assign done_o = (accept & (len_i == '0)) | (busy_q & pop & (out_left_q == LEN_W'(1)));

  assign word_iq.i = wb_dat_i[IQ_W-1:0];
  assign word_iq.q = wb_dat_i[HALF_W+IQ_W-1:HALF_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      cyc_q      <= 1'b0;
      adr_q      <= '0;
      req_left_q <= '0;
      out_left_q <= '0;
    end else if (accept) begin
      if (len_i != '0) begin
        busy_q     <= 1'b1;
        adr_q      <= base_i;
        req_left_q <= len_i;
        out_left_q <= len_i;
      end
    end else begin
      if (issue) cyc_q <= 1'b1;
      if (take) begin
        cyc_q      <= 1'b0;
        adr_q      <= adr_q + ADR_STEP;
        req_left_q <= req_left_q - LEN_W'(1);
      end
      if (busy_q && pop) begin
        out_left_q <= out_left_q - LEN_W'(1);
        if (out_left_q == LEN_W'(1)) busy_q <= 1'b0;
      end
    end
  end

  tx_dma_fifo #(
    .WIDTH($bits(iq_t)),
    .DEPTH(DEPTH)
  ) u_fifo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .push_i (take),
    .data_i (word_iq),
    .pop_i  (pop),
    .data_o (data_o),
    .empty_o(empty),
    .full_o (full),
    .count_o(fill_o)
  );

  assign valid_o  = ~empty;
  assign busy_o   = busy_q;
  assign wb_cyc_o = cyc_q;
  assign wb_stb_o = cyc_q;
  assign wb_adr_o = adr_q;

  logic unused_full;
  assign unused_full = full;
endmodule

// File: rtl/tx_src_mux.sv
module tx_src_mux
  import tx_iq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  src_e sel_i,
  input  logic tone_valid_i,
  input  iq_t  tone_data_i,
  output logic tone_ready_o,
  input  logic dma_valid_i,
  input  iq_t  dma_data_i,
  output logic dma_ready_o,
  output logic valid_o,
  output iq_t  data_o,
  input  logic ready_i,
  output src_e cur_sel_o
);
  src_e sel_q;

  // switch only when nothing is held unaccepted
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  sel_q <= SRC_TONE;
    else if (!valid_o || ready_i) sel_q <= sel_i;
  end

  assign valid_o      = (sel_q == SRC_DMA) ? dma_valid_i : tone_valid_i;
  assign data_o       = (sel_q == SRC_DMA) ? dma_data_i  : tone_data_i;
  assign tone_ready_o = ready_i & (sel_q == SRC_TONE);
  assign dma_ready_o  = ready_i & (sel_q == SRC_DMA);
  assign cur_sel_o    = sel_q;
endmodule

// File: rtl/tx_iq_source.sv
module tx_iq_source
  import tx_iq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LEN_W = 16,
  parameter int AMP   = (1 << (IQ_W - 1)) - 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              src_sel_i,
  input  logic              cfg_we_i,
  input  logic [1:0]        cfg_addr_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  input  logic [WORD_W-1:0] wb_dat_i,
  input  logic              wb_ack_i,
  output logic              tx_valid_o,
  input  logic              tx_ready_i,
  output logic [IQ_W-1:0]   tx_i_o,
  output logic [IQ_W-1:0]   tx_q_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_q;
  logic              flag_q, irq_en_q;
  logic              start, busy, done;
  logic              tone_valid, tone_ready, dma_valid, dma_ready;
  iq_t               tone_data, dma_data, out_data;
  logic [CNT_W-1:0]  dma_fill;
  src_e              cur_sel;

  assign start = cfg_we_i & (cfg_addr_i == REG_CTRL) & cfg_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q   <= '0;
      len_q    <= '0;
      flag_q   <= 1'b0;
      irq_en_q <= 1'b0;
    end else begin
      if (cfg_we_i && cfg_addr_i == REG_BASE) base_q <= cfg_wdata_i[ADDR_W-1:0];
      if (cfg_we_i && cfg_addr_i == REG_LEN)  len_q  <= cfg_wdata_i[LEN_W-1:0];
      if (cfg_we_i && cfg_addr_i == REG_IRQ)  irq_en_q <= cfg_wdata_i[1];
      if (done)                                              flag_q <= 1'b1;
      else if (cfg_we_i && cfg_addr_i == REG_IRQ && cfg_wdata_i[0]) flag_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (cfg_addr_i)
      REG_BASE: cfg_rdata_o = 32'(base_q);
      REG_LEN:  cfg_rdata_o = 32'(len_q);
      REG_CTRL: cfg_rdata_o = 32'(busy);
      default:  cfg_rdata_o = {30'd0, irq_en_q, flag_q};
    endcase
  end

  assign irq_o   = flag_q & irq_en_q;
  assign wb_we_o = 1'b0;

  tx_tone_gen #(.AMP(AMP)) u_tone (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ready_i(tone_ready),
    .valid_o(tone_valid),
    .data_o (tone_data)
  );

  tx_dma_reader #(.DEPTH(DEPTH), .LEN_W(LEN_W)) u_dma (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .base_i  (base_q),
    .len_i   (len_q),
    .busy_o  (busy),
    .done_o  (done),
    .wb_cyc_o(wb_cyc_o),
    .wb_stb_o(wb_stb_o),
    .wb_adr_o(wb_adr_o),
    .wb_dat_i(wb_dat_i),
    .wb_ack_i(wb_ack_i),
    .valid_o (dma_valid),
    .ready_i (dma_ready),
    .data_o  (dma_data),
    .fill_o  (dma_fill)
  );

  tx_src_mux u_mux (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (src_e'(src_sel_i)),
    .tone_valid_i(tone_valid),
    .tone_data_i (tone_data),
    .tone_ready_o(tone_ready),
    .dma_valid_i (dma_valid),
    .dma_data_i  (dma_data),
    .dma_ready_o (dma_ready),
    .valid_o     (tx_valid_o),
    .data_o      (out_data),
    .ready_i     (tx_ready_i),
    .cur_sel_o   (cur_sel)
  );

  assign tx_i_o = out_data.i;
  assign tx_q_o = out_data.q;
endmodule

// File: rtl/tx_iq_source_chk.sv
module tx_iq_source_chk
  import tx_iq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tx_valid_o,
  input logic              tx_ready_i,
  input logic [IQ_W-1:0]   tx_i_o,
  input logic [IQ_W-1:0]   tx_q_o,
  input logic              wb_cyc_o,
  input logic              wb_stb_o,
  input logic [ADDR_W-1:0] wb_adr_o,
  input logic              wb_ack_i,
  input logic              irq_o,
  input logic              cfg_we_i,
  input logic [1:0]        cfg_addr_i,
  input logic [CNT_W-1:0]  dma_fill,
  input src_e              cur_sel
);
  p_stall_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_i_o) && $stable(tx_q_o));

  p_sel_boundary_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> $stable(cur_sel));

  p_tone_valid_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cur_sel == SRC_TONE |-> tx_valid_o);

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_fill <= CNT_W'(DEPTH));

  p_stb_in_cyc_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o |-> wb_cyc_o);

  p_bus_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_cyc_o && !wb_ack_i |=> wb_cyc_o && $stable(wb_adr_o));

  p_irq_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !(cfg_we_i && cfg_addr_i == REG_IRQ) |=> irq_o);
endmodule

bind tx_iq_source tx_iq_source_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tx_valid_o(tx_valid_o),
  .tx_ready_i(tx_ready_i),
  .tx_i_o    (tx_i_o),
  .tx_q_o    (tx_q_o),
  .wb_cyc_o  (wb_cyc_o),
  .wb_stb_o  (wb_stb_o),
  .wb_adr_o  (wb_adr_o),
  .wb_ack_i  (wb_ack_i),
  .irq_o     (irq_o),
  .cfg_we_i  (cfg_we_i),
  .cfg_addr_i(cfg_addr_i),
  .dma_fill  (dma_fill),
  .cur_sel   (cur_sel)
);

// File: tb/tx_iq_source_bench.sv
module tx_iq_source_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        cyc, stb, wbwe, ack = 1'b0;
  logic [31:0] adr, rd_word = '0;
  logic        valid, ready = 1'b0;
  logic [11:0] s_i, s_q;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  int reads = 0, cyc_cycles = 0;
  logic [31:0] exp_adr = '0;
  int tphase = 0;
  logic [23:0] exp_q[$];

  always #4 clk = ~clk;

  tx_iq_source u_tx_iq_source (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(sel),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_we_o(wbwe), .wb_adr_o(adr),
    .wb_dat_i(rd_word), .wb_ack_i(ack),
    .tx_valid_o(valid), .tx_ready_i(ready), .tx_i_o(s_i), .tx_q_o(s_q),
    .irq_o(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] tone_iq(input int ph);
    case (ph % 4)
      0: return {12'h000, 12'h7FE};
      1: return {12'h7FE, 12'h000};
      2: return {12'h000, 12'h802};
      default: return {12'h802, 12'h000};
    endcase
  endfunction

  function automatic logic [23:0] mem_iq(input logic [31:0] a);
    logic [11:0] i, q;
    i = a[13:2] * 12'd37 + 12'd5;
    q = ~i ^ 12'h0A5;
    return {q, i};
  endfunction

  // R4 packing: sign-extended halves
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [23:0] p;
    p = mem_iq(a);
    return {{4{p[23]}}, p[23:12], {4{p[11]}}, p[11:0]};
  endfunction

  // memory model
  always @(posedge clk) begin
    if (!rst_n) ack <= 1'b0;
    else begin
      if (cyc) cyc_cycles++;
      ack <= cyc & stb & ~ack;
      rd_word <= mem_word(adr);
      if (cyc && stb && !ack) begin
        check(adr == exp_adr && !wbwe, "R7 read address", adr, exp_adr);
        exp_adr = exp_adr + 32'd4;
        reads++;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid && ready) begin
      if (exp_q.size() == 0) check(1'b0, "R6 unexpected sample", {8'd0, s_q, s_i}, 32'hFFFFFFFF);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        check({s_q, s_i} == e, "R2/R3/R4 sample", {8'd0, s_q, s_i}, {8'd0, e});
      end
    end
  end

  task automatic cfg_wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #2;
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #2;
    we = 1'b0;
  endtask

  task automatic cfg_rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1;
    d = rdata;
  endtask

  task automatic push_tone(input int n);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back(tone_iq(tphase));
      tphase++;
    end
  endtask

  task automatic tone_run(input int n);
    push_tone(n);
    @(posedge clk); #2; ready = 1'b1;
    repeat (n) @(posedge clk);
    #2; ready = 1'b0;
  endtask

  task automatic push_dma(input logic [31:0] base, input int n);
    for (int k = 0; k < n; k++) exp_q.push_back(mem_iq(base + 32'(4 * k)));
  endtask

  task automatic drain(input bit gappy, input string req);
    int t = 0;
    while (exp_q.size() != 0 && t < 3000) begin
      @(posedge clk); #2;
      ready = gappy ? ((t % 3) != 2) : 1'b1;
      t++;
    end
    @(posedge clk); #2; ready = 1'b0;
    check(exp_q.size() == 0, req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int snap;
    repeat (3) @(posedge clk);
    #2; rst_n = 1'b1;
    @(posedge clk); #2;

    // R1 reset state
    check(valid == 1'b1, "R1 tone valid", 32'(valid), 1);
    check({s_q, s_i} == tone_iq(0), "R1 first tone step", {8'd0, s_q, s_i}, {8'd0, tone_iq(0)});
    check(irq == 1'b0 && cyc == 1'b0, "R1 irq/cyc idle", {irq, cyc}, 0);
    for (int a = 0; a < 4; a++) begin
      cfg_rd(2'(a), r);
      check(r == 32'd0, "R1 register reset", r, 0);
    end

    // R2 tone sequence
    tone_run(9);

    // R5 register readback
    cfg_wr(2'd0, 32'h0000_1000);
    cfg_wr(2'd1, 32'd10);
    cfg_wr(2'd3, 32'd2);
    cfg_rd(2'd0, r); check(r == 32'h1000, "R5 base readback", r, 32'h1000);
    cfg_rd(2'd1, r); check(r == 32'd10, "R5 length readback", r, 10);
    cfg_rd(2'd3, r); check(r == 32'd2, "R5 irq enable readback", r, 2);

    // R3 switch while tone held stalled: held tone goes first
    sel = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check({s_q, s_i} == tone_iq(tphase), "R3 held tone during switch", {8'd0, s_q, s_i}, {8'd0, tone_iq(tphase)});
    push_tone(1);
    exp_adr = 32'h1000;
    push_dma(32'h1000, 10);
    cfg_wr(2'd2, 32'd1);
    cfg_rd(2'd2, r); check(r[0] == 1'b1, "R6 busy after start", r, 1);
    repeat (40) @(posedge clk);
    #2;
    // R8 stalled stream bounds the read-ahead
    check(reads == 4, "R8 reads while stalled", reads, 4);
    cfg_wr(2'd1, 32'd3);
    cfg_wr(2'd2, 32'd1); // R6 ignored start while busy
    drain(1'b1, "R4 buffer drained");
    repeat (6) @(posedge clk);
    #2;
    check(reads == 10, "R6 total reads", reads, 10);
    check(valid == 1'b0, "R6 no extra samples", 32'(valid), 0);
    cfg_rd(2'd2, r); check(r[0] == 1'b0, "R6 idle after done", r, 0);
    check(irq == 1'b1, "R9 irq after last sample", 32'(irq), 1);

    // R9 write of 0 keeps flag, write 1 clears
    cfg_wr(2'd3, 32'd2);
    check(irq == 1'b1, "R9 flag kept on write 0", 32'(irq), 1);
    cfg_wr(2'd3, 32'd1);
    cfg_rd(2'd3, r); check(r == 32'd0, "R9 flag cleared", r, 0);

    // R10 zero length, enable off
    cfg_wr(2'd1, 32'd0);
    snap = cyc_cycles;
    cfg_wr(2'd2, 32'd1);
    repeat (4) @(posedge clk);
    #2;
    cfg_rd(2'd3, r); check(r == 32'd1, "R10 flag on zero length", r, 1);
    check(irq == 1'b0, "R9 irq masked", 32'(irq), 0);
    check(cyc_cycles == snap, "R10 no bus cycle", cyc_cycles, snap);
    cfg_wr(2'd3, 32'd3);
    check(irq == 1'b0, "R9 clear with enable set", 32'(irq), 0);

    // R3 back to tone, resumes at stored step
    sel = 1'b0;
    repeat (3) @(posedge clk);
    tone_run(6);

    // second transfer, continuous ready
    sel = 1'b1;
    push_tone(1);
    cfg_wr(2'd0, 32'h0000_2000);
    cfg_wr(2'd1, 32'd5);
    exp_adr = 32'h2000;
    reads = 0;
    push_dma(32'h2000, 5);
    cfg_wr(2'd2, 32'd1);
    drain(1'b0, "R4 second buffer drained");
    repeat (4) @(posedge clk);
    #2;
    check(reads == 5, "R7 second transfer reads", reads, 5);
    check(irq == 1'b1, "R9 irq second transfer", 32'(irq), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule